// File: doc/BRIEF.md
# SD Card SPI-Mode Command Framer

This block sends one memory-card command over an SPI link and returns the card's one-byte R1 status. A controller gives it a 6-bit command index and a 32-bit argument through a valid/ready handshake. The block then drives a byte-exchange port towards an SPI shifter, one byte per handshake.

It first sends a 7-byte command frame. The frame opens with an all-ones filler byte and a byte that carries the start and transmit bits together with the index. The four argument bytes follow, and a checksum byte built from a CRC7 closes the frame. The block then sends all-ones bytes while it listens for the card's reply, within a bounded number of attempts. The reply byte is split into three exclusive outcomes: no card present, a communication CRC error, or some other error. A done pulse marks the end of the command.

The shifter, the chip-select policy and any data phase after the R1 byte belong to neighbouring logic.

Top module: `sdspi_cmd_framer`

## Requirements
- R1: After reset, cmd_ready is 1, byte_req is 0, cmd_done is 0, resp_r1 is 0x00 and all three error flags are 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. cmd_ready then stays 0 until the command completes. cmd_valid, cmd_index and cmd_arg have no effect while cmd_ready is 0.
- R3: Each command sends exactly 7 frame bytes in this order: 0xFF, then 0x40 OR the 6-bit index, then the argument from its most significant byte to its least significant byte, then the checksum byte.
- R4: The checksum byte is the CRC7 (polynomial x^7+x^3+1, initial value zero, most significant bit first) of the five index and argument bytes, placed in bits 7:1, with bit 0 set to 1. Examples: index 0 with argument 0 gives 0x95; index 8 with argument 0x000001AA gives 0x87.
- R5: Byte port: byte_req stays 1 and byte_tx stays stable until byte_ack is 1. A cycle with byte_req and byte_ack both 1 completes one transfer, and byte_rx is captured in that cycle. Every transfer after the frame sends 0xFF.
- R6: The first byte received after the frame is never accepted as the response. The first later byte with bit 7 clear is accepted, and polling then stops.
- R7: At most 8 bytes are received after the frame. If none is accepted, resp_r1 holds the last byte received.
- R8: resp_no_card is 1 exactly when resp_r1 is 0xFF.
- R9: resp_crc_err is 1 when resp_r1 is not 0xFF and bit 3 of resp_r1 is set.
- R10: resp_other_err is 1 when resp_r1 is not 0xFF, bit 3 is clear, and any bit from 7 down to 1 is set. At most one of the three flags is ever 1.
- R11: cmd_done is a single-cycle pulse in the cycle after the final transfer. resp_r1 and the flags are valid in that cycle and stay unchanged until the next command completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be accepted |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_done | output | 1 | One-cycle completion pulse |
| resp_r1 | output | 8 | Returned R1 byte |
| resp_no_card | output | 1 | No card answered (R1 = 0xFF) |
| resp_crc_err | output | 1 | Card reported a communication CRC error |
| resp_other_err | output | 1 | Card reported any other error bit |
| byte_req | output | 1 | Byte transfer request to the shifter |
| byte_tx | output | 8 | Byte to send |
| byte_ack | input | 1 | Shifter finished the transfer |
| byte_rx | input | 8 | Byte received in the transfer |

## Verification
On every cycle the assertions check several rules. byte_req and byte_tx must hold while a transfer waits for acknowledge, and the port must stay quiet while the block is idle. cmd_done must last one cycle, and the result must hold between completions. The flags must be exclusive and must agree with the R1 value. The number of transfers per command must fall between the minimum of two received bytes and the 15-transfer ceiling.

Other facts are visible only through the bench scenarios. These are the exact frame contents and checksum values, and which received byte is picked when the first byte or later bytes carry bit 7. They also include the last-byte result when polling runs out, and the fact that changing the inputs during a command does not alter the frame.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_POLL = 2'd2
  } fr_state_e;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] CMD_MARK   = 8'h40;
  localparam logic [6:0] CRC7_POLY  = 7'h09;

  typedef struct packed {
    logic no_card;
    logic crc_err;
    logic other_err;
  } r1_class_t;

  // One byte through the CRC7 register, msb first.
  function automatic logic [6:0] crc7_byte(input logic [6:0] c_in,
                                           input logic [7:0] d);
    logic [6:0] c;
    logic       fb;
    c = c_in;
    for (int b = 7; b >= 0; b--) begin
      fb = c[6] ^ d[b];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ CRC7_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/sdspi_crc7_step.sv
module sdspi_crc7_step (
  input  logic [6:0] crc_in,
  input  logic [7:0] data_in,
  output logic [6:0] crc_out
);
  import sdspi_pkg::*;

  always_comb crc_out = crc7_byte(crc_in, data_in);

endmodule

// File: rtl/sdspi_frame_byte.sv
module sdspi_frame_byte #(
  parameter int IDX_W     = 6,
  parameter int ARG_BYTES = 4,
  parameter int SEL_W     = 3
) (
  input  logic [SEL_W-1:0]       sel,
  input  logic [IDX_W-1:0]       cmd_idx,
  input  logic [ARG_BYTES*8-1:0] arg,
  input  logic [6:0]             crc,
  output logic [7:0]             frame_byte
);
  import sdspi_pkg::*;

  localparam int CRC_POS = ARG_BYTES + 2;

  logic [7:0] arg_byte [ARG_BYTES];

  // Argument bytes indexed in send order: most significant first.
  for (genvar g = 0; g < ARG_BYTES; g++) begin : g_argb
    assign arg_byte[g] = arg[(ARG_BYTES-1-g)*8 +: 8];
  end

  always_comb begin
    frame_byte = FILL_BYTE;
    if (sel == SEL_W'(1)) begin
      frame_byte = CMD_MARK | 8'(cmd_idx);
    end else if (sel == SEL_W'(CRC_POS)) begin
      frame_byte = {crc, 1'b1};
    end else begin
      for (int k = 0; k < ARG_BYTES; k++) begin
        if (sel == SEL_W'(k + 2)) frame_byte = arg_byte[k];
      end
    end
  end

endmodule

// File: rtl/sdspi_r1_classify.sv
module sdspi_r1_classify (
  input  logic [7:0]           r1,
  output sdspi_pkg::r1_class_t cls
);
  always_comb begin
    cls.no_card   = (r1 == 8'hFF);
    cls.crc_err   = !cls.no_card && r1[3];
    cls.other_err = !cls.no_card && !r1[3] && (r1[7:1] != 7'd0);
  end
endmodule

// File: rtl/sdspi_cmd_framer.sv
module sdspi_cmd_framer #(
  parameter int IDX_W     = 6,
  parameter int ARG_BYTES = 4,
  parameter int POLL_MAX  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [IDX_W-1:0]       cmd_index,
  input  logic [ARG_BYTES*8-1:0] cmd_arg,
  output logic                   cmd_done,
  output logic [7:0]             resp_r1,
  output logic                   resp_no_card,
  output logic                   resp_crc_err,
  output logic                   resp_other_err,
  output logic                   byte_req,
  output logic [7:0]             byte_tx,
  input  logic                   byte_ack,
  input  logic [7:0]             byte_rx
);
  import sdspi_pkg::*;

  localparam int ARG_W     = ARG_BYTES * 8;
  localparam int FRAME_LEN = ARG_BYTES + 3;
  localparam int SEL_W     = $clog2(FRAME_LEN + 1);
  localparam int POLL_W    = $clog2(POLL_MAX + 1);
  localparam int CRC_FIRST = 1;
  localparam int CRC_LAST  = ARG_BYTES + 1;

  fr_state_e         state_q;
  logic [SEL_W-1:0]  sel_q;
  logic [POLL_W-1:0] attempt_q;
  logic [6:0]        crc_q;
  logic [6:0]        crc_nxt;
  logic [IDX_W-1:0]  idx_q;
  logic [ARG_W-1:0]  arg_q;
  logic              req_q;
  logic              done_q;
  logic [7:0]        r1_q;
  r1_class_t         cls_q;
  r1_class_t         cls_rx;
  logic [7:0]        frame_byte;
  logic              xfer;
  logic              poll_take;

  sdspi_frame_byte #(
    .IDX_W    (IDX_W),
    .ARG_BYTES(ARG_BYTES),
    .SEL_W    (SEL_W)
  ) frame_i (
    .sel       (sel_q),
    .cmd_idx   (idx_q),
    .arg       (arg_q),
    .crc       (crc_q),
    .frame_byte(frame_byte)
  );

  sdspi_crc7_step crc_i (
    .crc_in (crc_q),
    .data_in(frame_byte),
    .crc_out(crc_nxt)
  );

  sdspi_r1_classify cls_i (
    .r1 (byte_rx),
    .cls(cls_rx)
  );

  assign xfer = req_q && byte_ack;

  // Response accepted on a later attempt with bit 7 clear, or forced at the cap.
  assign poll_take = ((attempt_q != '0) && !byte_rx[7]) ||
                     (attempt_q == POLL_W'(POLL_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sel_q     <= '0;
      attempt_q <= '0;
      crc_q     <= '0;
      idx_q     <= '0;
      arg_q     <= '0;
      req_q     <= 1'b0;
      done_q    <= 1'b0;
      r1_q      <= 8'h00;
      cls_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            idx_q   <= cmd_index;
            arg_q   <= cmd_arg;
            crc_q   <= '0;
            sel_q   <= '0;
            req_q   <= 1'b1;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (xfer) begin
            if (sel_q >= SEL_W'(CRC_FIRST) && sel_q <= SEL_W'(CRC_LAST))
              crc_q <= crc_nxt;
            sel_q <= sel_q + SEL_W'(1);
            if (sel_q == SEL_W'(FRAME_LEN - 1)) begin
              attempt_q <= '0;
              state_q   <= ST_POLL;
            end
          end
        end
        ST_POLL: begin
          if (xfer) begin
            if (poll_take) begin
              r1_q    <= byte_rx;
              cls_q   <= cls_rx;
              done_q  <= 1'b1;
              req_q   <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              attempt_q <= attempt_q + POLL_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready      = (state_q == ST_IDLE);
  assign cmd_done       = done_q;
  assign resp_r1        = r1_q;
  assign resp_no_card   = cls_q.no_card;
  assign resp_crc_err   = cls_q.crc_err;
  assign resp_other_err = cls_q.other_err;
  assign byte_req       = req_q;
  assign byte_tx        = (state_q == ST_POLL) ? FILL_BYTE : frame_byte;

endmodule

// File: rtl/sdspi_cmd_framer_chk.sv
module sdspi_cmd_framer_chk #(
  parameter int ARG_BYTES = 4,
  parameter int POLL_MAX  = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       cmd_done,
  input logic [7:0] resp_r1,
  input logic       resp_no_card,
  input logic       resp_crc_err,
  input logic       resp_other_err,
  input logic       byte_req,
  input logic [7:0] byte_tx,
  input logic       byte_ack
);
  localparam int FRAME_LEN = ARG_BYTES + 3;
  localparam int MAX_XFER  = FRAME_LEN + POLL_MAX;

  logic [7:0] xfer_cnt;

  always_ff @(posedge clk) begin
    if (rst) xfer_cnt <= 8'd0;
    else if (cmd_valid && cmd_ready) xfer_cnt <= 8'd0;
    else if (byte_req && byte_ack) xfer_cnt <= xfer_cnt + 8'd1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    byte_req && !byte_ack |=> byte_req && $stable(byte_tx)); // R5

  AST_PORT_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !byte_req); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done); // R11

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !cmd_done |-> $stable(resp_r1)); // R11

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resp_no_card, resp_crc_err, resp_other_err})); // R10

  AST_NO_CARD: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> (resp_no_card == (resp_r1 == 8'hFF))); // R8

  AST_CRC_FLAG: assert property (@(posedge clk) disable iff (rst)
    cmd_done && (resp_r1 != 8'hFF) |-> (resp_crc_err == resp_r1[3])); // R9

  AST_XFER_CAP: assert property (@(posedge clk) disable iff (rst)
    xfer_cnt <= 8'(MAX_XFER)); // R7

  AST_MIN_POLL: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> xfer_cnt >= 8'(FRAME_LEN + 2)); // R6

endmodule

bind sdspi_cmd_framer sdspi_cmd_framer_chk #(
  .ARG_BYTES(ARG_BYTES),
  .POLL_MAX (POLL_MAX)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_done      (cmd_done),
  .resp_r1       (resp_r1),
  .resp_no_card  (resp_no_card),
  .resp_crc_err  (resp_crc_err),
  .resp_other_err(resp_other_err),
  .byte_req      (byte_req),
  .byte_tx       (byte_tx),
  .byte_ack      (byte_ack)
);

// File: tb/sdspi_cmd_framer_tb_top.sv
`timescale 1ns/1ps
module sdspi_cmd_framer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_done;
  logic [7:0]  resp_r1;
  logic        resp_no_card, resp_crc_err, resp_other_err;
  logic        byte_req;
  logic [7:0]  byte_tx;
  logic        byte_ack = 1'b0;
  logic [7:0]  byte_rx = 8'hFF;

  int checks = 0;
  int errors = 0;

  logic [7:0] tx_log [32];
  int         xfer_n;
  logic [7:0] resp_q [16];
  int         resp_n;

  logic [7:0] got_r1;
  logic [2:0] got_fl;

  always #2.5 clk = ~clk;

  sdspi_cmd_framer dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .cmd_done(cmd_done), .resp_r1(resp_r1),
    .resp_no_card(resp_no_card), .resp_crc_err(resp_crc_err),
    .resp_other_err(resp_other_err),
    .byte_req(byte_req), .byte_tx(byte_tx),
    .byte_ack(byte_ack), .byte_rx(byte_rx)
  );

  // Shifter model: acknowledges each request one cycle after seeing it.
  initial begin
    xfer_n = 0;
    forever begin
      @(negedge clk);
      if (byte_ack) begin
        byte_ack = 1'b0;
        byte_rx  = 8'hFF;
      end else if (byte_req) begin
        if (xfer_n < 32) tx_log[xfer_n] = byte_tx;
        if (xfer_n >= 7 && (xfer_n - 7) < resp_n) byte_rx = resp_q[xfer_n - 7];
        else byte_rx = 8'hFF;
        byte_ack = 1'b1;
        xfer_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc_byte(input logic [5:0] idx,
                                              input logic [31:0] arg);
    logic [39:0] msg;
    logic [6:0]  c;
    logic        fb;
    msg = {2'b01, idx, arg};
    c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      fb = c[6] ^ msg[i];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return {c, 1'b1};
  endfunction

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input bit disturb);
    xfer_n = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_index = idx;
    cmd_arg   = arg;
    @(negedge clk);
    if (disturb) begin
      cmd_index = ~idx;
      cmd_arg   = ~arg;
    end else begin
      cmd_valid = 1'b0;
    end
    while (!cmd_done) @(negedge clk);
    cmd_valid = 1'b0;
    got_r1 = resp_r1;
    got_fl = {resp_no_card, resp_crc_err, resp_other_err};
    @(negedge clk);
    chk(cmd_done == 1'b0, "R11", "done width", cmd_done, 0);
  endtask

  task automatic chk_frame(input logic [5:0] idx, input logic [31:0] arg,
                           input string req);
    logic [7:0] exp [7];
    exp[0] = 8'hFF;
    exp[1] = 8'h40 | {2'b00, idx};
    exp[2] = arg[31:24];
    exp[3] = arg[23:16];
    exp[4] = arg[15:8];
    exp[5] = arg[7:0];
    exp[6] = ref_crc_byte(idx, arg);
    for (int i = 0; i < 7; i++)
      chk(tx_log[i] == exp[i], req, "frame byte", tx_log[i], exp[i]);
  endtask

  task automatic chk_result(input int n_xfer, input logic [7:0] r1,
                            input logic [2:0] fl, input string req);
    chk(xfer_n == n_xfer, req, "transfer count", xfer_n, n_xfer);
    chk(got_r1 == r1, req, "r1", got_r1, r1);
    chk(got_fl == fl, req, "flags {nc,crc,oth}", got_fl, fl);
    for (int i = 7; i < n_xfer; i++)
      chk(tx_log[i] == 8'hFF, "R5", "poll fill byte", tx_log[i], 8'hFF);
  endtask

  task automatic t_reset;
    chk(cmd_ready == 1'b1, "R1", "ready", cmd_ready, 1);
    chk(byte_req == 1'b0, "R1", "req", byte_req, 0);
    chk(cmd_done == 1'b0, "R1", "done", cmd_done, 0);
    chk(resp_r1 == 8'h00, "R1", "r1", resp_r1, 0);
    chk({resp_no_card, resp_crc_err, resp_other_err} == 3'b000, "R1", "flags",
        {resp_no_card, resp_crc_err, resp_other_err}, 0);
  endtask

  // Index 0, idle reply on the second byte.
  task automatic t_go_idle;
    resp_q[0] = 8'hFF; resp_q[1] = 8'h01; resp_n = 2;
    run_cmd(6'd0, 32'h0, 1'b0);
    chk_frame(6'd0, 32'h0, "R3");
    chk(tx_log[6] == 8'h95, "R4", "crc idx0", tx_log[6], 8'h95);
    chk_result(9, 8'h01, 3'b000, "R6");
  endtask

  // First byte has bit 7 clear but must be skipped.
  task automatic t_skip_first;
    resp_q[0] = 8'h00; resp_q[1] = 8'h05; resp_n = 2;
    run_cmd(6'd55, 32'h0, 1'b0);
    chk_frame(6'd55, 32'h0, "R3");
    chk_result(9, 8'h05, 3'b001, "R6");
  endtask

  // Index 8 with check pattern, CRC error reported on third byte.
  task automatic t_crc_reply;
    resp_q[0] = 8'hFF; resp_q[1] = 8'hFF; resp_q[2] = 8'h09; resp_n = 3;
    run_cmd(6'd8, 32'h0000_01AA, 1'b0);
    chk_frame(6'd8, 32'h0000_01AA, "R4");
    chk(tx_log[6] == 8'h87, "R4", "crc idx8", tx_log[6], 8'h87);
    chk_result(10, 8'h09, 3'b010, "R9");
  endtask

  // No card: all bytes 0xFF, cap reached.
  task automatic t_no_card;
    resp_n = 0;
    run_cmd(6'd17, 32'h1234_5678, 1'b0);
    chk_frame(6'd17, 32'h1234_5678, "R3");
    chk_result(15, 8'hFF, 3'b100, "R8");
  endtask

  // Cap reached with a last byte that is not 0xFF.
  task automatic t_cap_last;
    resp_q[0] = 8'h00;
    for (int i = 1; i < 7; i++) resp_q[i] = 8'hFF;
    resp_q[7] = 8'hC1; resp_n = 8;
    run_cmd(6'd24, 32'hDEAD_BEEF, 1'b0);
    chk_result(15, 8'hC1, 3'b001, "R7");
  endtask

  // Inputs changing while busy must not alter the frame; results held.
  task automatic t_busy_ignore;
    logic [7:0] held;
    resp_q[0] = 8'hFF; resp_q[1] = 8'hFF; resp_q[2] = 8'hFF; resp_q[3] = 8'h0C;
    resp_n = 4;
    run_cmd(6'd12, 32'hA5C3_0F81, 1'b1);
    chk_frame(6'd12, 32'hA5C3_0F81, "R2");
    chk_result(11, 8'h0C, 3'b010, "R2");
    held = resp_r1;
    repeat (6) @(negedge clk);
    chk(resp_r1 == held, "R11", "r1 held", resp_r1, held);
    chk(cmd_ready == 1'b1 && byte_req == 1'b0, "R2", "idle after cmd",
        {cmd_ready, byte_req}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    resp_n = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_go_idle();
    t_skip_first();
    t_crc_reply();
    t_no_card();
    t_cap_last();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule